// File: doc/BRIEF.md
# Receive Frame Ring Writer

This block takes incoming Ethernet frames, one byte per beat, and decides from the destination address whether to keep each frame. Kept frames are written through a byte write port into a circular buffer in local memory. The buffer is made of 256-byte pages and is bounded by a first page and an exclusive end page. Each stored frame begins four bytes into the current page. The four bytes in front of the data form a header. This header carries the receive status, the page where the following frame will start, and the stored length.

The surrounding controller owns the ring registers and passes them in: first page, end page, the boundary page up to which the host has read, and the current page. It also supplies the receive configuration byte, the station address, the 64-bit group hash table and a stopped flag. When a frame has been committed, the block gives back the new current page together with the status byte and a one-cycle done pulse. The controller loads the new page into its current-page register.

The input is a valid/ready stream with start and end markers. A byte moves only on a cycle where both `s_valid` and `s_ready` are high. The producer must hold its byte and markers stable while `s_ready` is low. `s_ready` stays high while the block is idle or collecting a frame. It drops for the cycles in which the block makes its decision, pads the frame and writes the header.

Top module: `rx_ring_writer`

## Requirements
- R1: A byte is consumed on every cycle where `s_valid` and `s_ready` are both high. `s_ready` is high when idle and while collecting a frame. It is low from the cycle after the end-marked byte until the cycle after `rx_done`. A byte without a start marker arriving while idle is consumed and discarded.
- R2: A frame that begins while `rx_stopped` is high produces no memory write and no `rx_done`.
- R3: Free bytes are computed from page numbers. If current is below boundary, they are (boundary − current)·256. Otherwise they are (end − first)·256 − (current − boundary)·256. When the frame starts with fewer than 1518 free bytes, it produces no memory write and no `rx_done`.
- R4: With `rx_cfg` bit 4 set, every frame of legal length is kept.
- R5: Otherwise, a destination of all ones is kept only when `rx_cfg` bit 2 is set.
- R6: Otherwise, a destination whose first byte has bit 0 set is a group address. It is kept only when `rx_cfg` bit 3 is set and bit k of `hash_tbl` is set. Here k is bits 31:26 of a 32-bit register that starts at all ones and is updated for each of the six destination bytes, bits taken LSB first: shift left by one, then XOR with 0x04C11DB7 when the old bit 31 differs from the incoming bit.
- R7: Otherwise, the frame is kept only when its six destination bytes equal `station_addr`. The first byte on the wire is compared with bits 7:0.
- R8: Frames shorter than 6 bytes or longer than 1514 bytes are not kept. No header is written for them and `rx_done` is not raised.
- R9: Data byte i of a kept frame goes to address current·256 + 4 + i. An address that reaches end·256 continues at first·256. Frames shorter than 60 bytes are followed by zero bytes up to a length of 60.
- R10: The header occupies addresses current·256 + 0..3 and holds, in that order: the status byte, the next page, total[7:0] and total[15:8], where total = padded length + 4.
- R11: The next page is current + ⌊(total + 4 + 255)/256⌋. If that is at or past the end page, (end − first) is subtracted.
- R12: The status is 0x01, or 0x21 for a destination whose first byte has bit 0 set. `rx_done` is high for exactly one cycle, 5 + (pad bytes) cycles after the end-marked byte is consumed. At the same time `cur_next` and `rx_status` take the new values, and they hold them until the next kept frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_valid | input | 1 | Input byte valid |
| s_ready | output | 1 | Block can take a byte |
| s_data | input | 8 | Frame byte |
| s_sop | input | 1 | First byte of a frame |
| s_eop | input | 1 | Last byte of a frame |
| rx_stopped | input | 1 | Controller stopped; frames are dropped |
| pg_start | input | PW | First page of the ring |
| pg_stop | input | PW | End page of the ring (exclusive) |
| pg_bound | input | PW | Boundary page read up to by the host |
| pg_cur | input | PW | Current page, where the next frame is stored |
| rx_cfg | input | 8 | Receive configuration: bit 4 keep all, bit 3 group, bit 2 all-ones |
| station_addr | input | 48 | Station address, first wire byte in bits 7:0 |
| hash_tbl | input | 64 | Group hash table, bit k selects hash value k |
| wr_en | output | 1 | Memory byte write strobe |
| wr_addr | output | PW+8 | Memory byte address |
| wr_data | output | 8 | Memory byte data |
| cur_next | output | PW | Page where the next frame will start |
| rx_status | output | 8 | Status byte of the last kept frame |
| rx_done | output | 1 | One-cycle pulse when a frame is committed |

## Verification
Every memory write leaves a register and is seen one cycle after the byte that causes it is consumed. The bench therefore records writes into a byte model at the falling edge and checks memory contents only after the frame has settled. The decision, padding and header take one cycle, one cycle per pad byte and four cycles. `rx_done` is therefore due exactly 5 + pad cycles after the end byte. The bench counts rising edges from the consumption of the end byte to the falling edge where it sees `rx_done`, and compares that count with this sum. It also checks that `s_ready` is low on the first falling edge after the end byte. For rejected frames it waits a fixed window longer than the longest header sequence, then confirms that no header byte was written and that `cur_next` did not move.

// File: rtl/rxw_pkg.sv
package rxw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_CHECK,
    ST_PAD,
    ST_HDR
  } rxw_state_e;

  localparam int DA_BYTES  = 6;
  localparam int HDR_BYTES = 4;
  localparam int MIN_LEN   = 60;

  // receive configuration bit positions
  localparam int CFG_ALL   = 4;
  localparam int CFG_GROUP = 3;
  localparam int CFG_BCAST = 2;

  localparam logic [31:0] HASH_POLY  = 32'h04C1_1DB7;
  localparam logic [7:0]  STAT_OK    = 8'h01;
  localparam logic [7:0]  STAT_GROUP = 8'h20;
endpackage

// File: rtl/rxw_hash.sv
module rxw_hash
  import rxw_pkg::*;
(
  input  logic [31:0] crc_in,
  input  logic [7:0]  din,
  output logic [31:0] crc_out
);
  // one byte of the address hash, bits taken LSB first
  always_comb begin
    crc_out = crc_in;
    for (int j = 0; j < 8; j++) begin
      if (crc_out[31] ^ din[j])
        crc_out = {crc_out[30:0], 1'b0} ^ HASH_POLY;
      else
        crc_out = {crc_out[30:0], 1'b0};
    end
  end
endmodule

// File: rtl/rxw_filter.sv
module rxw_filter
  import rxw_pkg::*;
(
  input  logic [7:0]  cfg,
  input  logic [47:0] dst,
  input  logic [47:0] station,
  input  logic [63:0] hash_tbl,
  input  logic [5:0]  hidx,
  output logic        accept,
  output logic        group
);
  logic bcast, uni_hit;
  logic [4:0] unused_cfg;

  assign unused_cfg = {cfg[7:5], cfg[1:0]};
  assign bcast   = &dst;
  assign group   = dst[0];
  assign uni_hit = (dst == station);

  always_comb begin
    if (cfg[CFG_ALL])
      accept = 1'b1;
    else if (bcast)
      accept = cfg[CFG_BCAST];
    else if (group)
      accept = cfg[CFG_GROUP] & hash_tbl[hidx];
    else
      accept = uni_hit;
  end
endmodule

// File: rtl/rxw_ring.sv
module rxw_ring
  import rxw_pkg::*;
#(
  parameter int PW   = 8,
  parameter int LW   = 11,
  parameter int NEED = 1518
) (
  input  logic [PW-1:0] start_pg,
  input  logic [PW-1:0] stop_pg,
  input  logic [PW-1:0] bound_pg,
  input  logic [PW-1:0] cur_pg,
  input  logic [PW-1:0] base_pg,
  input  logic [LW-1:0] len,
  output logic          full,
  output logic [PW-1:0] next_pg
);
  localparam int AW = PW + 8;
  localparam int SW = LW + 1;

  logic [PW-1:0] ring_pg, gap_pg, lead_pg;
  logic [AW:0]   avail_b;
  logic [SW-1:0] span;
  logic [PW:0]   pages, sum, wrapped;
  logic          unused_wrap;

  assign ring_pg = stop_pg - start_pg;
  assign gap_pg  = cur_pg - bound_pg;
  assign lead_pg = bound_pg - cur_pg;

  // free space in bytes ahead of the current page
  always_comb begin
    if (cur_pg < bound_pg)
      avail_b = {1'b0, lead_pg, 8'h00};
    else
      avail_b = {1'b0, ring_pg, 8'h00} - {1'b0, gap_pg, 8'h00};
  end
  assign full = avail_b < (AW+1)'(NEED);

  // pages used by header, data and trailing allowance, rounded up
  assign span    = SW'(len) + SW'(2*HDR_BYTES + 255);
  assign pages   = (PW+1)'(span >> 8);
  assign sum     = {1'b0, base_pg} + pages;
  assign wrapped = (sum >= {1'b0, stop_pg}) ? (sum - {1'b0, ring_pg}) : sum;
  assign next_pg = wrapped[PW-1:0];
  assign unused_wrap = wrapped[PW];
endmodule

// File: rtl/rx_ring_writer.sv
module rx_ring_writer
  import rxw_pkg::*;
#(
  parameter int PW      = 8,
  parameter int MAX_LEN = 1514,
  parameter int NEED    = 1518
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           s_valid,
  output logic           s_ready,
  input  logic [7:0]     s_data,
  input  logic           s_sop,
  input  logic           s_eop,
  input  logic           rx_stopped,
  input  logic [PW-1:0]  pg_start,
  input  logic [PW-1:0]  pg_stop,
  input  logic [PW-1:0]  pg_bound,
  input  logic [PW-1:0]  pg_cur,
  input  logic [7:0]     rx_cfg,
  input  logic [47:0]    station_addr,
  input  logic [63:0]    hash_tbl,
  output logic           wr_en,
  output logic [PW+7:0]  wr_addr,
  output logic [7:0]     wr_data,
  output logic [PW-1:0]  cur_next,
  output logic [7:0]     rx_status,
  output logic           rx_done
);
  localparam int AW = PW + 8;
  localparam int LW = $clog2(MAX_LEN + HDR_BYTES + 1);

  rxw_state_e    state;
  logic [PW-1:0] base;
  logic [AW-1:0] ptr;
  logic [LW-1:0] len;
  logic          drop;
  logic [47:0]   dst;
  logic [31:0]   crc;
  logic [1:0]    hdr_i;

  logic          beat, first, take, in_da, drop_now;
  logic          ring_full, accept, group;
  logic [LW-1:0] len_now, total;
  logic [AW-1:0] addr_now, addr_inc, adv;
  logic [31:0]   hash_in, hash_out;
  logic [PW-1:0] next_pg;
  logic [7:0]    stat, hdr_byte;
  logic [25:0]   unused_crc;

  assign s_ready  = (state == ST_IDLE) || (state == ST_RX);
  assign beat     = s_valid & s_ready;
  assign first    = beat & (state == ST_IDLE) & s_sop;
  assign take     = first | (beat & (state == ST_RX));
  assign len_now  = first ? LW'(1)
                  : ((len == LW'(MAX_LEN)) ? len : len + LW'(1));
  assign drop_now = first ? (rx_stopped | ring_full)
                  : (drop | (len == LW'(MAX_LEN)));
  assign in_da    = len_now <= LW'(DA_BYTES);
  assign addr_now = (state == ST_IDLE) ? {pg_cur, 8'(HDR_BYTES)} : ptr;
  assign addr_inc = addr_now + AW'(1);
  assign adv      = (addr_inc == {pg_stop, 8'h00}) ? {pg_start, 8'h00} : addr_inc;
  assign hash_in  = first ? '1 : crc;
  assign total    = len + LW'(HDR_BYTES);
  assign stat     = STAT_OK | (group ? STAT_GROUP : 8'h00);
  assign unused_crc = crc[25:0];

  always_comb begin
    case (hdr_i)
      2'd0:    hdr_byte = stat;
      2'd1:    hdr_byte = 8'(next_pg);
      2'd2:    hdr_byte = total[7:0];
      default: hdr_byte = 8'(total >> 8);
    endcase
  end

  rxw_hash u_hash (
    .crc_in  (hash_in),
    .din     (s_data),
    .crc_out (hash_out)
  );

  rxw_filter u_filter (
    .cfg      (rx_cfg),
    .dst      (dst),
    .station  (station_addr),
    .hash_tbl (hash_tbl),
    .hidx     (crc[31:26]),
    .accept   (accept),
    .group    (group)
  );

  rxw_ring #(.PW(PW), .LW(LW), .NEED(NEED)) u_ring (
    .start_pg (pg_start),
    .stop_pg  (pg_stop),
    .bound_pg (pg_bound),
    .cur_pg   (pg_cur),
    .base_pg  (base),
    .len      (len),
    .full     (ring_full),
    .next_pg  (next_pg)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      base      <= '0;
      ptr       <= '0;
      len       <= '0;
      drop      <= 1'b0;
      dst       <= '0;
      crc       <= '1;
      hdr_i     <= '0;
      wr_en     <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
      cur_next  <= '0;
      rx_status <= '0;
      rx_done   <= 1'b0;
    end else begin
      wr_en   <= 1'b0;
      rx_done <= 1'b0;
      if (take) begin
        if (first) base <= pg_cur;
        wr_en   <= ~drop_now;
        wr_addr <= addr_now;
        wr_data <= s_data;
        ptr     <= adv;
        len     <= len_now;
        drop    <= drop_now;
        if (in_da) begin
          crc <= hash_out;
          dst <= {s_data, dst[47:8]};
        end
        state <= s_eop ? ST_CHECK : ST_RX;
      end else begin
        case (state)
          ST_CHECK: begin
            hdr_i <= '0;
            if (drop || (len < LW'(DA_BYTES)) || !accept)
              state <= ST_IDLE;
            else if (len < LW'(MIN_LEN))
              state <= ST_PAD;
            else
              state <= ST_HDR;
          end
          ST_PAD: begin
            wr_en   <= 1'b1;
            wr_addr <= ptr;
            wr_data <= 8'h00;
            ptr     <= adv;
            len     <= len + LW'(1);
            if (len + LW'(1) == LW'(MIN_LEN)) state <= ST_HDR;
          end
          ST_HDR: begin
            wr_en   <= 1'b1;
            wr_addr <= {base, 8'(hdr_i)};
            wr_data <= hdr_byte;
            hdr_i   <= hdr_i + 2'd1;
            if (hdr_i == 2'd3) begin
              cur_next  <= next_pg;
              rx_status <= stat;
              rx_done   <= 1'b1;
              state     <= ST_IDLE;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R1: the block refuses input on the cycle before it commits a frame
  a_r1_holdoff: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |-> $past(!s_ready));

  // R2: a frame started while stopped writes nothing on the following cycle
  a_r2_stopped_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && s_valid && s_sop && rx_stopped) |=> !wr_en);

  // R9: every write lands inside the ring
  a_r9_write_in_ring: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_addr >= {pg_start, 8'h00}) && (wr_addr < {pg_stop, 8'h00}));

  // R12: done is a single-cycle pulse
  a_r12_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |=> !rx_done);

  // R12: only the two legal status codes are reported
  a_r12_status_code: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |-> (rx_status == 8'h01) || (rx_status == 8'h21));
endmodule

// File: tb/rx_ring_writer_bench.sv
module rx_ring_writer_bench;
  localparam int PW = 8;
  localparam int FIRST = 8'h40;
  localparam int LAST  = 8'h48;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          s_valid = 1'b0, s_sop = 1'b0, s_eop = 1'b0;
  logic [7:0]    s_data = '0;
  logic          s_ready;
  logic          rx_stopped = 1'b0;
  logic [PW-1:0] pg_start = 8'(FIRST), pg_stop = 8'(LAST);
  logic [PW-1:0] pg_bound = 8'(FIRST), pg_cur = 8'(FIRST);
  logic [7:0]    rx_cfg = '0;
  logic [47:0]   station_addr = 48'h5544_3322_1100;
  logic [63:0]   hash_tbl = '0;
  logic          wr_en, rx_done;
  logic [PW+7:0] wr_addr;
  logic [7:0]    wr_data, rx_status;
  logic [PW-1:0] cur_next;

  always #5 clk = ~clk;

  rx_ring_writer u_rx_ring_writer (
    .clk, .rst_n, .s_valid, .s_ready, .s_data, .s_sop, .s_eop,
    .rx_stopped, .pg_start, .pg_stop, .pg_bound, .pg_cur, .rx_cfg,
    .station_addr, .hash_tbl, .wr_en, .wr_addr, .wr_data,
    .cur_next, .rx_status, .rx_done
  );

  logic [7:0] mem [int];
  logic [7:0] fb [0:1599];
  int cyc = 0, nwr = 0, ndone = 0, done_cyc = 0, eop_cyc = 0;
  int nchk = 0, nfail = 0;
  bit finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n) begin
      if (wr_en) begin
        mem[int'(wr_addr)] = wr_data;
        nwr++;
      end
      if (rx_done) begin
        ndone++;
        done_cyc = cyc;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nfail++;
    $display("FAIL R1 watchdog: actual hung expected finished");
    report();
  end

  function automatic logic [5:0] hidx(input logic [47:0] d);
    logic [31:0] c = '1;
    for (int i = 0; i < 6; i++) begin
      for (int j = 0; j < 8; j++) begin
        logic fbk = c[31] ^ d[8*i + j];
        c = {c[30:0], 1'b0};
        if (fbk) c = c ^ 32'h04C1_1DB7;
      end
    end
    return c[31:26];
  endfunction

  function automatic int rd(input int a);
    if (mem.exists(a)) return int'(mem[a]);
    return -1;
  endfunction

  task automatic send(input int len);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      s_valid = 1'b1; s_data = fb[i];
      s_sop = (i == 0); s_eop = (i == len - 1);
      while (!s_ready) @(negedge clk);
      @(posedge clk);
    end
    @(negedge clk);
    s_valid = 1'b0; s_sop = 1'b0; s_eop = 1'b0;
    eop_cyc = cyc;
    chk(s_ready == 1'b0, "R1", "ready after end byte", int'(s_ready), 0);
  endtask

  task automatic frame(input logic [47:0] dst, input int len, input int seed,
                       input bit ok, input logic [7:0] stat, input string req);
    int base, d0, L, P, a, bad, pbad, expn, tot, hcnt, e, g;
    logic [PW-1:0] old_next;
    int hb [4];
    for (int i = 0; i < len; i++)
      fb[i] = (i < 6) ? dst[8*i +: 8] : 8'(seed + i * 13);
    mem.delete();
    nwr = 0;
    d0 = ndone;
    base = int'(pg_cur);
    old_next = cur_next;
    send(len);
    repeat (80) @(negedge clk);
    if (ok) begin
      L = (len < 60) ? 60 : len;
      P = L - len;
      tot = L + 4;
      expn = base + (tot + 4 + 255) / 256;
      if (expn >= LAST) expn -= (LAST - FIRST);
      chk(ndone == d0 + 1, req, "frame kept", ndone - d0, 1);
      chk(done_cyc - eop_cyc == 5 + P, "R12", "done latency",
          done_cyc - eop_cyc, 5 + P);
      chk(int'(cur_next) == expn, "R11", "next page", int'(cur_next), expn);
      chk(rx_status == stat, "R12", "status", int'(rx_status), int'(stat));
      hb[0] = int'(stat); hb[1] = expn; hb[2] = tot & 255; hb[3] = tot >> 8;
      for (int k = 0; k < 4; k++)
        chk(rd(base * 256 + k) == hb[k], "R10", "header byte",
            rd(base * 256 + k), hb[k]);
      a = base * 256 + 4;
      bad = 0; pbad = 0;
      for (int i = 0; i < L; i++) begin
        e = (i < len) ? int'(fb[i]) : 0;
        g = rd(a);
        if (g != e) begin
          if (i < len) bad++; else pbad++;
        end
        a++;
        if (a == LAST * 256) a = FIRST * 256;
      end
      chk(bad == 0, "R9", "data bytes misplaced", bad, 0);
      if (P > 0) chk(pbad == 0, "R9", "pad bytes not zero", pbad, 0);
      pg_cur = cur_next;
      pg_bound = cur_next;
    end else begin
      hcnt = 0;
      for (int k = 0; k < 4; k++) if (mem.exists(base * 256 + k)) hcnt++;
      chk(ndone == d0, req, "frame dropped", ndone - d0, 0);
      chk(hcnt == 0, req, "no header written", hcnt, 0);
      chk(cur_next == old_next, req, "next page held",
          int'(cur_next), int'(old_next));
    end
  endtask

  initial begin
    logic [47:0] d;
    logic [5:0] h;
    int lens [7] = '{100, 255, 256, 257, 500, 1000, 1514};
    int sp [6][3] = '{'{8'h40, 8'h45, 0}, '{8'h40, 8'h46, 1},
                      '{8'h45, 8'h44, 1}, '{8'h43, 8'h41, 1},
                      '{8'h44, 8'h41, 0}, '{8'h42, 8'h42, 1}};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(s_ready == 1'b1, "R1", "reset ready", int'(s_ready), 1);
    chk(wr_en == 1'b0 && rx_done == 1'b0, "R12", "reset strobes",
        int'({wr_en, rx_done}), 0);
    chk(rx_status == 8'h00, "R12", "reset status", int'(rx_status), 0);
    chk(cur_next == '0, "R11", "reset next page", int'(cur_next), 0);

    // stray byte while idle is discarded
    @(negedge clk); s_valid = 1'b1; s_data = 8'hAA;
    @(posedge clk); @(negedge clk); s_valid = 1'b0;
    repeat (4) @(negedge clk);
    chk(nwr == 0, "R1", "stray byte written", nwr, 0);

    // unicast length sweep, covering padding and ring wrap
    for (int n = 6; n <= 70; n++)
      frame(station_addr, n, n * 3, 1, 8'h01, "R9");
    foreach (lens[i])
      frame(station_addr, lens[i], i, 1, 8'h01, "R11");

    // unicast mismatch in each byte position
    for (int k = 0; k < 6; k++)
      frame(station_addr ^ (48'h2 << (8 * k)), 64, k, 0, 8'h01, "R7");

    // keep-all mode
    rx_cfg = 8'h10;
    frame(station_addr ^ 48'h0200, 64, 7, 1, 8'h01, "R4");
    frame('1, 64, 8, 1, 8'h21, "R4");
    rx_cfg = 8'h00;

    // all-ones destination
    frame('1, 64, 9, 0, 8'h21, "R5");
    rx_cfg = 8'h04;
    frame('1, 64, 10, 1, 8'h21, "R5");
    rx_cfg = 8'h00;

    // group destinations through the hash table
    for (int k = 0; k < 8; k++) begin
      d = {8'(k * 37 + 5), 8'h00, 8'h00, 8'h5E, 8'h00, 8'h01};
      h = hidx(d);
      rx_cfg = 8'h08;
      hash_tbl = 64'h1 << h;
      frame(d, 64, k, 1, 8'h21, "R6");
      hash_tbl = ~(64'h1 << h);
      frame(d, 64, k, 0, 8'h21, "R6");
      rx_cfg = 8'h00;
      hash_tbl = 64'h1 << h;
      frame(d, 64, k, 0, 8'h21, "R6");
    end
    hash_tbl = '0;

    // length limits
    for (int n = 1; n <= 5; n++)
      frame(station_addr, n, n, 0, 8'h01, "R8");
    frame(station_addr, 1515, 3, 0, 8'h01, "R8");

    // stopped controller
    rx_stopped = 1'b1;
    frame(station_addr, 64, 4, 0, 8'h01, "R2");
    chk(nwr == 0, "R2", "writes while stopped", nwr, 0);
    rx_stopped = 1'b0;

    // free-space threshold
    foreach (sp[i]) begin
      pg_cur = 8'(sp[i][0]);
      pg_bound = 8'(sp[i][1]);
      frame(station_addr, 64, i, sp[i][2] != 0, 8'h01, "R3");
      if (sp[i][2] == 0) chk(nwr == 0, "R3", "writes with ring full", nwr, 0);
    end

    report();
  end
endmodule